// File: doc/BRIEF.md
# Privilege-Gated Control/Status Register Bank

This block is a small bank of control and status registers for a processor core. A request gives a 12-bit register address, a 2-bit privilege level and a request-valid strobe. The bank answers in the same cycle with a 64-bit read value and a hit flag. A register claims the request only when the address matches its own parameterised address, the privilege is nonzero and the request is valid.

The bank holds four register kinds:
- a read-only constant;
- a read-only mirror of a narrower external status input;
- a read/write register in which only a parameterised bit range is stored;
- a 16-bit event counter that advances on a tick input and can be overwritten by software.

A write lands on the next clock edge. In the counter a software write takes priority over a tick in the same cycle. A priority mux returns the data of the hit register. If two registers share an address, the one with the lower index wins, in the order constant, status, masked, counter.

Top module: `csr_bank`

## Requirements
- R1: `hit` is 1 only when `req_valid` is 1, `priv` is nonzero and `addr` equals one register's address; otherwise `hit` is 0 and `rd_data` is all zero.
- R2: A hit on the constant register returns `CONST_VALUE` on `rd_data`.
- R3: A hit on the status register returns `status_in` zero-extended to 64 bits, following the input in the same cycle.
- R4: With `wr_en` high on a hit of the masked register, bits `MASK_LO`..`MASK_HI` of `wr_data` read back from the next cycle on; bits outside that range always read 0.
- R5: A write to the masked register with `priv` = 0, with `req_valid` low or with another address leaves its contents unchanged.
- R6: After reset the counter and the masked register read 0. This holds also for a reset applied mid-run.
- R7: With `wr_en` high on a hit of the counter, it loads `wr_data[15:0]` on the next edge even when `tick` is high; bits 63..16 of its read value are 0.
- R8: Without a write hit, `tick` high adds one to the counter modulo 2^16 (0xFFFF wraps to 0x0000); `tick` low holds it.
- R9: With `wr_en` high and the counter not hit, the counter counts `tick` or holds exactly as with no write.
- R10: If two registers share an address, the lower-indexed one drives `rd_data` (constant before status before masked before counter).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid strobe |
| addr | input | ADDR_W (12) | Register address |
| priv | input | 2 | Privilege level; 0 selects nothing |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W (64) | Write data |
| tick | input | 1 | Counter event input |
| status_in | input | STATUS_W (52) | External status mirrored by the status register |
| rd_data | output | DATA_W (64) | Read data of the hit register, zero if none |
| hit | output | 1 | A register claims the request |

## Verification
The main instance uses a masked range of bits 4 to 59, so that both the low and the high unstored bits can be checked. It uses a 52-bit status input, so the zero-extension above bit 51 is in reach. A second instance shares the same inputs. In it the counter sits at the constant's address and the masked register sits at the status address, which makes the lower-index priority of the read mux observable. Counter wrap is reached by a software load of 0xFFFE followed by ticks, not by 65536 tick cycles.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int NUM_REGS = 4;
  typedef enum logic [1:0] {
    IDX_CONST  = 2'd0,
    IDX_STATUS = 2'd1,
    IDX_MASKED = 2'd2,
    IDX_COUNT  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/csr_hit_decode.sv
module csr_hit_decode #(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MATCH  = '0
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  output logic              sel
);
  always_comb begin
    sel = req_valid && (priv != 2'b00) && (addr == MATCH);
  end
endmodule

// File: rtl/csr_masked_reg.sv
module csr_masked_reg #(
  parameter int DATA_W  = 64,
  parameter int MASK_LO = 2,
  parameter int MASK_HI = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_val
);
  logic [MASK_HI:MASK_LO] store_q, store_d;
  logic                   load_en;

  always_comb begin
    load_en = sel && wr_en;
    store_d = wr_data[MASK_HI:MASK_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (load_en) begin
      store_q <= store_d;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= MASK_LO && b <= MASK_HI) begin : g_kept
      assign rd_val[b] = store_q[b];
    end else begin : g_tied
      assign rd_val[b] = 1'b0;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en) |=> $stable(store_q)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en) |=> (rd_val[MASK_HI:MASK_LO] == $past(wr_data[MASK_HI:MASK_LO]))); // R4
endmodule

// File: rtl/csr_tick_counter.sv
module csr_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (sel && wr_en) || tick;
    if (sel && wr_en) begin
      cnt_d = wr_val;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en) |=> (cnt_q == $past(wr_val))); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && wr_en) && tick) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && wr_en) && !tick) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 64,
  parameter int                STATUS_W    = 52,
  parameter int                CNT_W       = 16,
  parameter int                MASK_LO     = 2,
  parameter int                MASK_HI     = 63,
  parameter logic [DATA_W-1:0] CONST_VALUE = 64'hDEAD_BEEF_FEED_FACE,
  parameter logic [ADDR_W-1:0] CONST_ADDR  = 12'h123,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h124,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 12'h340,
  parameter logic [ADDR_W-1:0] CNT_ADDR    = 12'hC00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          priv,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                tick,
  input  logic [STATUS_W-1:0] status_in,
  output logic [DATA_W-1:0]   rd_data,
  output logic                hit
);
  localparam logic [NUM_REGS*ADDR_W-1:0] ADDR_TABLE =
    {CNT_ADDR, MASK_ADDR, STATUS_ADDR, CONST_ADDR};

  logic [NUM_REGS-1:0] sel;
  logic [DATA_W-1:0]   src [NUM_REGS];
  logic [DATA_W-1:0]   masked_val;
  logic [CNT_W-1:0]    cnt_val;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    csr_hit_decode #(
      .ADDR_W (ADDR_W),
      .MATCH  (ADDR_TABLE[i*ADDR_W +: ADDR_W])
    ) u_dec (
      .req_valid (req_valid),
      .addr      (addr),
      .priv      (priv),
      .sel       (sel[i])
    );
  end

  csr_masked_reg #(
    .DATA_W  (DATA_W),
    .MASK_LO (MASK_LO),
    .MASK_HI (MASK_HI)
  ) u_masked (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel[IDX_MASKED]),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_val  (masked_val)
  );

  csr_tick_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel[IDX_COUNT]),
    .wr_en  (wr_en),
    .wr_val (wr_data[CNT_W-1:0]),
    .tick   (tick),
    .count  (cnt_val)
  );

  always_comb begin
    src[IDX_CONST]  = CONST_VALUE;
    src[IDX_STATUS] = DATA_W'(status_in);
    src[IDX_MASKED] = masked_val;
    src[IDX_COUNT]  = DATA_W'(cnt_val);
  end

  // Scan from the top index down so that the lowest selected index is the last assignment.
  always_comb begin
    rd_data = '0;
    hit     = 1'b0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (sel[i]) begin
        rd_data = src[i];
        hit     = 1'b1;
      end
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0)); // R1
  AST_NO_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv == 2'b00) || !req_valid) |-> !hit); // R1
  AST_CONST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && addr == CONST_ADDR) |-> (rd_data == CONST_VALUE)); // R2
  AST_CNT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && addr == CNT_ADDR && addr != CONST_ADDR && addr != STATUS_ADDR && addr != MASK_ADDR)
      |-> (rd_data[DATA_W-1:CNT_W] == '0)); // R7
endmodule

// File: tb/sim_csr_bank.sv
module sim_csr_bank;
  localparam int          MLO    = 4;
  localparam int          MHI    = 59;
  localparam logic [63:0] CVAL   = 64'hDEAD_BEEF_FEED_FACE;
  localparam logic [11:0] A_CON  = 12'h123;
  localparam logic [11:0] A_STA  = 12'h124;
  localparam logic [11:0] A_MSK  = 12'h340;
  localparam logic [11:0] A_CNT  = 12'hC00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, wr_en, tick;
  logic [11:0] addr;
  logic [1:0]  priv;
  logic [63:0] wr_data;
  logic [51:0] status_in;
  logic [63:0] rd_data, rd_data1;
  logic        hit, hit1;

  int tests = 0;
  int fails = 0;
  logic [63:0] mask_m;
  logic [15:0] cnt_m;
  logic [63:0] keep_bits;

  always #4 clk = ~clk;  // 125 MHz

  csr_bank #(
    .MASK_LO (MLO), .MASK_HI (MHI), .CONST_VALUE (CVAL),
    .CONST_ADDR (A_CON), .STATUS_ADDR (A_STA), .MASK_ADDR (A_MSK), .CNT_ADDR (A_CNT)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .addr (addr), .priv (priv),
    .wr_en (wr_en), .wr_data (wr_data), .tick (tick), .status_in (status_in),
    .rd_data (rd_data), .hit (hit)
  );

  // Collision instance: counter shares the constant address, masked shares the status address.
  csr_bank #(
    .MASK_LO (MLO), .MASK_HI (MHI), .CONST_VALUE (CVAL),
    .CONST_ADDR (A_CON), .STATUS_ADDR (A_STA), .MASK_ADDR (A_STA), .CNT_ADDR (A_CON)
  ) u1 (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .addr (addr), .priv (priv),
    .wr_en (wr_en), .wr_data (wr_data), .tick (tick), .status_in (status_in),
    .rd_data (rd_data1), .hit (hit1)
  );

  function automatic logic [64:0] expect0();
    if (!req_valid || priv == 2'b00) return '0;
    if (addr == A_CON) return {1'b1, CVAL};
    if (addr == A_STA) return {1'b1, 12'h000, status_in};
    if (addr == A_MSK) return {1'b1, mask_m};
    if (addr == A_CNT) return {1'b1, 48'h0, cnt_m};
    return '0;
  endfunction

  function automatic logic [64:0] expect1();
    if (!req_valid || priv == 2'b00) return '0;
    if (addr == A_CON) return {1'b1, CVAL};
    if (addr == A_STA) return {1'b1, 12'h000, status_in};
    return '0;
  endfunction

  task automatic cyc(input logic v, input logic [11:0] a, input logic [1:0] p,
                     input logic we, input logic [63:0] wd, input logic tk,
                     input string tag);
    logic [64:0] e0, e1;
    logic        s;
    req_valid = v; addr = a; priv = p; wr_en = we; wr_data = wd; tick = tk;
    #1;
    e0 = expect0();
    e1 = expect1();
    tests++;
    if ({hit, rd_data} !== e0) begin
      fails++;
      $display("FAIL %s: hit/rd_data got %b/%h expected %b/%h", tag, hit, rd_data, e0[64], e0[63:0]);
    end
    tests++;
    if ({hit1, rd_data1} !== e1) begin
      fails++;
      $display("FAIL R10: collision instance got %b/%h expected %b/%h", hit1, rd_data1, e1[64], e1[63:0]);
    end
    @(posedge clk);
    s = v && (p != 2'b00);
    if (s && we && a == A_MSK) mask_m = wd & keep_bits;
    if (s && we && a == A_CNT) cnt_m = wd[15:0];
    else if (tk) cnt_m = cnt_m + 16'd1;
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0; wr_en = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    mask_m = '0;
    cnt_m  = '0;
    rst_n  = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 64; b++) keep_bits[b] = (b >= MLO && b <= MHI);
    rst_n = 1'b0; req_valid = 1'b0; addr = '0; priv = '0; wr_en = 1'b0;
    wr_data = '0; tick = 1'b0; status_in = '0; mask_m = '0; cnt_m = '0;
    apply_reset();

    // R6: reset state
    cyc(1, A_MSK, 2'd3, 0, '0, 0, "R6");
    cyc(1, A_CNT, 2'd1, 0, '0, 0, "R6");
    // R2 / R1: constant and select gating
    cyc(1, A_CON, 2'd3, 0, '0, 0, "R2");
    cyc(1, A_CON, 2'd2, 0, '0, 0, "R2");
    cyc(1, A_CON, 2'd0, 0, '0, 0, "R1");
    cyc(0, A_CON, 2'd3, 0, '0, 0, "R1");
    cyc(1, 12'h7FF, 2'd3, 0, '0, 0, "R1");
    // R3: status mirror patterns
    status_in = 52'hF_FFFF_FFFF_FFFF;
    cyc(1, A_STA, 2'd1, 0, '0, 0, "R3");
    status_in = 52'hA_5A5A_1234_C3C3;
    cyc(1, A_STA, 2'd3, 0, '0, 0, "R3");
    // R4: masked writes
    cyc(1, A_MSK, 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4");
    cyc(1, A_MSK, 2'd3, 0, '0, 0, "R4");
    cyc(1, A_MSK, 2'd1, 1, 64'h1234_5678_9ABC_DEF0, 0, "R4");
    cyc(1, A_MSK, 2'd1, 0, '0, 0, "R4");
    // R5: blocked writes
    cyc(1, A_MSK, 2'd0, 1, 64'hAAAA_AAAA_AAAA_AAAA, 0, "R5");
    cyc(0, A_MSK, 2'd3, 1, 64'h5555_5555_5555_5555, 0, "R5");
    cyc(1, A_CON, 2'd3, 1, 64'h0F0F_0F0F_0F0F_0F0F, 0, "R5");
    cyc(1, A_MSK, 2'd3, 0, '0, 0, "R5");
    // R8: counting and holding
    for (int k = 0; k < 3; k++) cyc(1, A_CNT, 2'd3, 0, '0, 1, "R8");
    cyc(1, A_CNT, 2'd3, 0, '0, 0, "R8");
    cyc(1, A_CNT, 2'd3, 0, '0, 0, "R8");
    // R7: write beats tick
    cyc(1, A_CNT, 2'd2, 1, 64'h7777_0000_3333_FFFE, 1, "R7");
    cyc(1, A_CNT, 2'd2, 0, '0, 1, "R7");
    cyc(1, A_CNT, 2'd2, 0, '0, 1, "R8");
    cyc(1, A_CNT, 2'd2, 0, '0, 0, "R8");
    // R9: write elsewhere while ticking or idle
    cyc(1, A_MSK, 2'd3, 1, 64'h0000_0000_0000_0040, 1, "R9");
    cyc(1, A_CNT, 2'd3, 0, '0, 0, "R9");
    cyc(1, A_CON, 2'd3, 1, 64'h0000_0000_0000_9999, 0, "R9");
    cyc(1, A_CNT, 2'd0, 1, 64'h0000_0000_0000_8888, 1, "R9");
    cyc(0, A_CNT, 2'd3, 1, 64'h0000_0000_0000_8888, 0, "R9");
    cyc(1, A_CNT, 2'd3, 0, '0, 0, "R9");
    // R10: collision reads on u1 (checked in every cycle as well)
    cyc(1, A_CON, 2'd3, 0, '0, 1, "R10");
    cyc(1, A_STA, 2'd3, 0, '0, 0, "R10");
    // R6: reset mid-run
    apply_reset();
    cyc(1, A_CNT, 2'd3, 0, '0, 0, "R6");
    cyc(1, A_MSK, 2'd3, 0, '0, 0, "R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule